// File: doc/BRIEF.md
# Link Character Receiver with Error Detection

This block sits on the receive side of a point-to-point serial-style link that has been widened to a parallel character bus. Each cycle in which `rx_valid` is high carries one link character. The block checks the character's parity, sorts it into a data or end-of-packet character for the host, a flow-control token for the local transmitter, or a NULL keep-alive, and tracks the protocol rules that span several characters.

Host-bound characters leave on a valid/ready stream towards a receive FIFO kept outside the block. The link cannot be stalled. `fifo_wr_valid` is offered in the same cycle as the incoming character, and a transfer happens only when `fifo_wr_ready` is high in that cycle. If the FIFO is not ready, the character is lost and an overflow error is recorded. A flow-control token that passes the credit check appears as a one-cycle pulse on `fct_pulse`. Five sticky error flags report to the link state machine. Only reset clears them.

Character layout, with `DATA_W` = 8 by default: bits `[DATA_W-1:0]` hold the payload, bit `DATA_W` is the control flag (1 = control character), and bit `DATA_W+1` is a parity bit. The parity bit is chosen so that all `DATA_W+2` bits together hold an odd number of ones. For a control character, payload bits `[1:0]` select the kind: 0 = flow-control token, 1 = end of packet, 2 = error end of packet, 3 = escape. An escape followed by a flow-control token forms a NULL.

Top module: `link_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all five error flags and `link_up` are 0. With `rx_valid` low, `fifo_wr_valid` and `fct_pulse` are 0.
- R2: A valid character whose total number of ones is even sets `err_parity` at the next clock edge. The character is discarded: no push, no pulse, no NULL. A pending escape is cancelled.
- R3: A valid data character (control flag 0) with correct parity raises `fifo_wr_valid` in the same cycle, with `fifo_wr_data` = {1'b0, payload}.
- R4: A valid end-of-packet or error-end-of-packet control character (codes 1 and 2) is pushed the same way, with `fifo_wr_data` = {1'b1, payload}.
- R5: A flow-control token (control code 0) that is not preceded by an escape gives `fct_pulse` = 1 in its own cycle, provided the outstanding-credit count is below `MAX_CREDIT`. Such a token is never pushed to the FIFO. The accepted token increments the count.
- R6: An escape followed by a flow-control token is a NULL. It gives no push and no pulse, and it sets `link_up` at the next edge. `link_up` then stays high until reset.
- R7: An escape whose next valid, parity-correct character is anything other than a flow-control token sets `err_escape`. That following character is discarded.
- R8: A flow-control token that arrives while `MAX_CREDIT` (default 7) credits are outstanding sets `err_fct` and gives no pulse. Each cycle with `credit_take` high lowers a nonzero count by one.
- R9: A character offered on `fifo_wr_valid` while `fifo_wr_ready` is low sets `err_char` at that edge. Tokens and NULLs never set it.
- R10: Once `link_up` is set, `DISC_CYCLES` consecutive cycles with `rx_valid` low set `err_disc`. Any valid cycle restarts the count. Idle time before `link_up` never sets it.
- R11: Every error flag, once set, stays set until `rst`.
- R12: Cycles with `rx_valid` low push nothing, pulse nothing, and do not change the escape state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_char | input | DATA_W+2 | Link character: parity, control flag, payload |
| rx_valid | input | 1 | Qualifies `rx_char` in this cycle |
| fifo_wr_valid | output | 1 | A host-bound character is offered this cycle |
| fifo_wr_ready | input | 1 | Receive FIFO can accept this cycle |
| fifo_wr_data | output | DATA_W+1 | Control flag (MSB) and payload |
| credit_take | input | 1 | Transmitter consumed one credit |
| fct_pulse | output | 1 | One accepted flow-control token |
| link_up | output | 1 | A NULL has been received since reset |
| err_parity | output | 1 | Sticky parity error |
| err_escape | output | 1 | Sticky escape sequence error |
| err_disc | output | 1 | Sticky disconnect timeout |
| err_char | output | 1 | Sticky receive overflow |
| err_fct | output | 1 | Sticky credit overrun |

## Verification
The assertions check on every cycle the following rules: an idle or bad-parity character is never decoded; a character after an escape is never pushed or pulsed; the credit count stays within its bound and moves by one per accepted token; an unaccepted offer always leads to an overflow flag; error flags never fall; and a disconnect flag only rises after an idle cycle on a live link. Only the bench scenarios can show the rest. These are the exact payload carried into the FIFO for every byte value, the cycle in which the disconnect timer expires relative to the first NULL, recovery of credit after a take, and whether a discarded character truly leaves no trace on the stream or the flags.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  typedef enum logic [1:0] {
    CC_FCT = 2'd0,
    CC_EOP = 2'd1,
    CC_EEP = 2'd2,
    CC_ESC = 2'd3
  } ctrl_code_e;

  localparam int ERR_PARITY = 0;
  localparam int ERR_ESCAPE = 1;
  localparam int ERR_DISC   = 2;
  localparam int ERR_CHAR   = 3;
  localparam int ERR_FCT    = 4;
  localparam int ERR_COUNT  = 5;
endpackage

// File: rtl/lrx_decode.sv
module lrx_decode
  import lrx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHAR_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_valid,
  output logic              par_bad,
  output logic              esc_bad,
  output logic              null_seen,
  output logic              fct_seen,
  output logic              nchar_seen,
  output logic [DATA_W:0]   nchar_word
);
  logic       esc_q, esc_d;
  logic       par_ok, is_ctrl;
  ctrl_code_e code;

  always_comb begin
    par_ok     = ^rx_char;
    is_ctrl    = rx_char[DATA_W];
    code       = ctrl_code_e'(rx_char[1:0]);
    nchar_word = {is_ctrl, rx_char[DATA_W-1:0]};
    par_bad    = 1'b0;
    esc_bad    = 1'b0;
    null_seen  = 1'b0;
    fct_seen   = 1'b0;
    nchar_seen = 1'b0;
    esc_d      = esc_q;
    if (rx_valid) begin
      if (!par_ok) begin
        par_bad = 1'b1;
        esc_d   = 1'b0;
      end else if (esc_q) begin
        esc_d = 1'b0;
        if (is_ctrl && code == CC_FCT) null_seen = 1'b1;
        else                           esc_bad   = 1'b1;
      end else if (is_ctrl) begin
        case (code)
          CC_FCT:  fct_seen   = 1'b1;
          CC_ESC:  esc_d      = 1'b1;
          default: nchar_seen = 1'b1;
        endcase
      end else begin
        nchar_seen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) esc_q <= 1'b0;
    else     esc_q <= esc_d;
  end

  a_r2_bad_parity_dropped: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !(^rx_char)) |-> !(nchar_seen || fct_seen || null_seen));

  a_r7_after_escape_not_passed: assert property (@(posedge clk) disable iff (rst)
    esc_q |-> !(nchar_seen || fct_seen));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !(nchar_seen || fct_seen || null_seen || esc_bad || par_bad));

  a_r12_idle_keeps_escape: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> esc_q == $past(esc_q));
endmodule

// File: rtl/lrx_credit.sv
module lrx_credit #(
  parameter int MAX_CREDIT = 7,
  localparam int CRED_W = $clog2(MAX_CREDIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fct_in,
  input  logic take,
  output logic fct_out,
  output logic overrun
);
  logic [CRED_W-1:0] cnt_q;
  logic              at_max, dec;

  always_comb begin
    at_max  = (cnt_q == CRED_W'(MAX_CREDIT));
    fct_out = fct_in && !at_max;
    overrun = fct_in && at_max;
    dec     = take && (cnt_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (fct_out && !dec) cnt_q <= cnt_q + 1'b1;
    else if (!fct_out && dec) cnt_q <= cnt_q - 1'b1;
  end

  a_r8_credit_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CRED_W'(MAX_CREDIT));

  a_r5_credit_step: assert property (@(posedge clk) disable iff (rst)
    (fct_out && !take) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r8_take_step: assert property (@(posedge clk) disable iff (rst)
    (!fct_in && take && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/lrx_watchdog.sv
module lrx_watchdog #(
  parameter int DISC_CYCLES = 20,
  localparam int CNT_W = $clog2(DISC_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic rx_valid,
  output logic armed,
  output logic timeout
);
  logic [CNT_W-1:0] idle_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DISC_CYCLES - 1);

  assign timeout = armed && !rx_valid && (idle_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      idle_q <= '0;
    end else begin
      if (arm) armed <= 1'b1;
      if (rx_valid || !armed) idle_q <= '0;
      else if (idle_q != LAST) idle_q <= idle_q + 1'b1;
    end
  end

  a_r10_count_clears: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> idle_q == '0);

  a_r6_armed_holds: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);
endmodule

// File: rtl/link_rx.sv
module link_rx
  import lrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MAX_CREDIT  = 7,
  parameter int DISC_CYCLES = 20,
  localparam int CHAR_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_valid,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic [DATA_W:0]   fifo_wr_data,
  input  logic              credit_take,
  output logic              fct_pulse,
  output logic              link_up,
  output logic              err_parity,
  output logic              err_escape,
  output logic              err_disc,
  output logic              err_char,
  output logic              err_fct
);
  logic par_bad, esc_bad, null_seen, fct_seen, nchar_seen;
  logic fct_over, disc_to;
  logic [ERR_COUNT-1:0] err_set, err_q;

  lrx_decode #(.DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_valid(rx_valid),
    .par_bad(par_bad), .esc_bad(esc_bad), .null_seen(null_seen),
    .fct_seen(fct_seen), .nchar_seen(nchar_seen), .nchar_word(fifo_wr_data)
  );

  lrx_credit #(.MAX_CREDIT(MAX_CREDIT)) u_credit (
    .clk(clk), .rst(rst), .fct_in(fct_seen), .take(credit_take),
    .fct_out(fct_pulse), .overrun(fct_over)
  );

  lrx_watchdog #(.DISC_CYCLES(DISC_CYCLES)) u_watchdog (
    .clk(clk), .rst(rst), .arm(null_seen), .rx_valid(rx_valid),
    .armed(link_up), .timeout(disc_to)
  );

  assign fifo_wr_valid = nchar_seen;

  always_comb begin
    err_set             = '0;
    err_set[ERR_PARITY] = par_bad;
    err_set[ERR_ESCAPE] = esc_bad;
    err_set[ERR_DISC]   = disc_to;
    err_set[ERR_CHAR]   = nchar_seen && !fifo_wr_ready;
    err_set[ERR_FCT]    = fct_over;
  end

  for (genvar i = 0; i < ERR_COUNT; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst)             err_q[i] <= 1'b0;
      else if (err_set[i]) err_q[i] <= 1'b1;
    end
  end

  assign err_parity = err_q[ERR_PARITY];
  assign err_escape = err_q[ERR_ESCAPE];
  assign err_disc   = err_q[ERR_DISC];
  assign err_char   = err_q[ERR_CHAR];
  assign err_fct    = err_q[ERR_FCT];

  a_r11_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (($past(err_q) & ~err_q) == '0));

  a_r9_overflow_flagged: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr_valid && !fifo_wr_ready) |=> err_char);

  a_r10_disc_needs_link: assert property (@(posedge clk) disable iff (rst)
    $rose(err_disc) |-> ($past(link_up) && $past(!rx_valid)));

  a_r5_token_not_pushed: assert property (@(posedge clk) disable iff (rst)
    !(fct_pulse && fifo_wr_valid));

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (err_q == '0 && !link_up));
endmodule

// File: tb/link_rx_test.sv
module link_rx_test;
  localparam int DW = 8;
  localparam int NDISC = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW+1:0] rx_char = '0;
  logic rx_valid = 1'b0;
  logic fifo_wr_ready = 1'b1;
  logic credit_take = 1'b0;
  logic fifo_wr_valid, fct_pulse, link_up;
  logic err_parity, err_escape, err_disc, err_char, err_fct;
  logic [DW:0] fifo_wr_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_rx #(.DATA_W(DW), .MAX_CREDIT(7), .DISC_CYCLES(NDISC)) uut (
    .clk(clk), .rst(rst), .rx_char(rx_char), .rx_valid(rx_valid),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_ready(fifo_wr_ready),
    .fifo_wr_data(fifo_wr_data), .credit_take(credit_take),
    .fct_pulse(fct_pulse), .link_up(link_up), .err_parity(err_parity),
    .err_escape(err_escape), .err_disc(err_disc), .err_char(err_char),
    .err_fct(err_fct)
  );

  function automatic logic [DW+1:0] mk(input logic ctl, input logic [DW-1:0] d,
                                       input logic bad);
    logic p;
    p = ~^{ctl, d};
    return {p ^ bad, ctl, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [DW+1:0] c);
    @(negedge clk);
    rx_valid = v;
    rx_char  = c;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rx_valid = 1'b0;
    credit_take = 1'b0;
    fifo_wr_ready = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 flags", {27'd0, err_parity, err_escape, err_disc, err_char, err_fct}, 32'd0);
    check("R1 link_up", link_up, 0);
    check("R1 idle outputs", {fifo_wr_valid, fct_pulse}, 0);

    // R3 every data byte is pushed with flag 0
    for (int d = 0; d < 256; d++) begin
      drive(1'b1, mk(1'b0, DW'(d), 1'b0));
      check("R3 push valid", fifo_wr_valid, 1);
      check("R3 push word", fifo_wr_data, {1'b0, DW'(d)});
    end
    // R4 end-of-packet kinds carry flag 1
    drive(1'b1, mk(1'b1, 8'h01, 1'b0));
    check("R4 eop push", {fifo_wr_valid, fifo_wr_data}, {1'b1, 1'b1, 8'h01});
    drive(1'b1, mk(1'b1, 8'h02, 1'b0));
    check("R4 eep push", {fifo_wr_valid, fifo_wr_data}, {1'b1, 1'b1, 8'h02});
    idle();
    check("R12 idle no push", {fifo_wr_valid, fct_pulse}, 0);
    idle();
    check("R2 no parity err yet", err_parity, 0);

    // R2 bad parity over all bytes and both flag values
    for (int d = 0; d < 512; d++) begin
      drive(1'b1, mk(d[8], DW'(d), 1'b1));
      check("R2 bad char dropped", {fifo_wr_valid, fct_pulse}, 0);
    end
    idle();
    check("R2 parity flag", err_parity, 1);
    check("R9 no overflow", err_char, 0);
    check("R7 no escape err", err_escape, 0);

    // R5/R8 credit accounting
    do_reset();
    for (int k = 0; k < 7; k++) begin
      drive(1'b1, mk(1'b1, 8'h00, 1'b0));
      check("R5 token pulse", {fct_pulse, fifo_wr_valid}, 2'b10);
    end
    idle();
    check("R8 no overrun at 7", err_fct, 0);
    drive(1'b1, mk(1'b1, 8'h00, 1'b0));
    check("R8 eighth no pulse", fct_pulse, 0);
    idle();
    check("R8 overrun flag", err_fct, 1);
    @(negedge clk);
    credit_take = 1'b1;
    @(negedge clk);
    credit_take = 1'b0;
    drive(1'b1, mk(1'b1, 8'h00, 1'b0));
    check("R8 credit returned", fct_pulse, 1);
    idle();
    check("R11 fct flag held", err_fct, 1);

    // R6 NULL and R10 disconnect
    do_reset();
    for (int k = 0; k < 3 * NDISC; k++) idle();
    check("R10 no disc before link", err_disc, 0);
    drive(1'b1, mk(1'b1, 8'h03, 1'b0));
    check("R6 escape silent", {fifo_wr_valid, fct_pulse}, 0);
    drive(1'b1, mk(1'b1, 8'h00, 1'b0));
    check("R6 null no pulse", {fifo_wr_valid, fct_pulse}, 0);
    idle();
    check("R6 link_up", link_up, 1);
    for (int k = 0; k < NDISC - 5; k++) idle();
    drive(1'b1, mk(1'b0, 8'h5a, 1'b0));
    for (int k = 0; k < NDISC - 1; k++) idle();
    check("R10 restart by valid", err_disc, 0);
    idle();
    check("R10 exactly N-1 idle", err_disc, 0);
    idle();
    check("R10 disc at N", err_disc, 1);
    drive(1'b1, mk(1'b0, 8'h11, 1'b0));
    idle();
    check("R11 disc held", err_disc, 1);

    // R7 escape errors
    do_reset();
    drive(1'b1, mk(1'b1, 8'h03, 1'b0));
    drive(1'b1, mk(1'b0, 8'h77, 1'b0));
    check("R7 follower dropped", fifo_wr_valid, 0);
    idle();
    check("R7 escape flag", err_escape, 1);
    check("R6 no link on bad escape", link_up, 0);
    drive(1'b1, mk(1'b0, 8'h33, 1'b0));
    check("R7 escape consumed", {fifo_wr_valid, fifo_wr_data}, {1'b1, 1'b0, 8'h33});

    // R9 overflow
    do_reset();
    @(negedge clk);
    fifo_wr_ready = 1'b0;
    drive(1'b1, mk(1'b1, 8'h00, 1'b0));
    idle();
    check("R9 token no overflow", err_char, 0);
    drive(1'b1, mk(1'b0, 8'hc3, 1'b0));
    check("R9 offered", fifo_wr_valid, 1);
    idle();
    check("R9 overflow flag", err_char, 1);
    check("R2 unaffected", err_parity, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule